// File: doc/BRIEF.md
# Split Transmit/Receive Interrupt Status Controller

This block keeps the interrupt cause flags of an Ethernet MAC and drives two separate interrupt lines, one for the transmit side and one for the receive side. The transmit and receive engines report events as single-cycle pulses. Each pulse sets a sticky cause bit. Software clears cause bits by writing ones, and it programs an enable mask through a small write port with a 2-bit register select. The current status, enable, command and global-status words are presented on output buses so that they can be read back.

The 32-bit status word is split into two halves. Bits 31..16 hold the transmit causes and bits 15..0 hold the receive causes. Bit 0 of each half is a summary bit that has no storage of its own. The summary is set while any of its half's three interrupt-class causes is both set and enabled. The interrupt line of a half is the summary bit ANDed with the summary bit's own enable.

The command word holds the transmit and receive enables and two mode fields. A falling edge of either enable records a halted flag in a separate global-status word. A write of the command word with its soft-reset bit set returns the block to its reset state, except for the two mode fields.

Top module: `irqStatusTop`

## Requirements
- R1: After reset, every output is zero: the status, enable, command and global-status words and both interrupt lines.
- R2: An event pulse on `rxEvents[i]` sets status bit i, and one on `txEvents[i]` sets status bit 16+i. The new value is visible in the cycle after the pulse. Event bit 0 of each half has no effect.
- R3: A cause bit holds its value until software clears it. A write with regSel=1 clears exactly the status bits written as 1. Cleared bits read 0 in the next cycle, and the other bits are unchanged.
- R4: When an event and a clear of the same cause bit fall in one cycle, the bit ends up set.
- R5: Status bit 16 (the transmit summary) is 1 when any of bits 18 (done), 23 (descriptor unavailable) or 24 (bus error) is set together with the same bit of the enable word. Otherwise it is 0. No other transmit cause affects it.
- R6: Status bit 0 (the receive summary) is 1 when any of bits 4 (good frame), 10 (descriptor unavailable) or 11 (bus error) is set together with the same bit of the enable word. Otherwise it is 0. No other receive cause affects it.
- R7: `txIrq` equals status bit 16 AND enable bit 16. `rxIrq` equals status bit 0 AND enable bit 0.
- R8: Receive events never change bits 31..16, and transmit events never change bits 15..0.
- R9: A regSel=2 write with data bit 24 set acts as a soft reset. In the next cycle the status, enable and global-status words read 0 and both interrupt lines are low. The command word keeps only its bits 20 (operating mode) and 21 (loopback), and events in the reset cycle are dropped.
- R10: A regSel=2 write without bit 24 stores the data as the command word, with bit 8 as transmit enable and bit 0 as receive enable. If the write takes transmit enable from 1 to 0, global-status bit 1 is set. If it takes receive enable from 1 to 0, global-status bit 0 is set. A regSel=3 write clears the global-status bits written as 1.
- R11: A regSel=0 write replaces the enable word. The summary bits and interrupt lines follow a new event, clear or enable value in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | 0 enable, 1 status clear, 2 command, 3 global-status clear |
| regWrData | input | 32 | Write data |
| txEvents | input | 16 | Transmit event pulses, bit i maps to status bit 16+i |
| rxEvents | input | 16 | Receive event pulses, bit i maps to status bit i |
| statusWord | output | 32 | Cause bits with the two summary bits |
| enableWord | output | 32 | Enable mask |
| cmdWord | output | 32 | Command word |
| globalStatus | output | 32 | Bit 1 transmit halted, bit 0 receive halted |
| txIrq | output | 1 | Transmit interrupt line |
| rxIrq | output | 1 | Receive interrupt line |

## Verification
The properties take it that event pulses and register writes are sampled only at rising edges. They also take it that a soft-reset write overrides everything else in its cycle. The stimulus drives every input on the falling edge and holds it for exactly one cycle. It mixes sparse random event pulses with random writes to all four selects, with soft resets kept rare so that state can build up. Directed sequences cover the collision of an event with a clear, summary masking, enable edges and soft reset over non-zero state.

// File: rtl/irqStatusPkg.sv
package irqStatusPkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_ENABLE     = 2'd0,
    SEL_STATUS_CLR = 2'd1,
    SEL_COMMAND    = 2'd2,
    SEL_GLOBAL_CLR = 2'd3
  } regSelE;

  // command word fields
  localparam int CMD_RXON   = 0;
  localparam int CMD_TXON   = 8;
  localparam int CMD_OPMODE = 20;
  localparam int CMD_LOOP   = 21;
  localparam int CMD_SWR    = 24;
  localparam logic [WORD_W-1:0] CMD_KEEP = (WORD_W'(1) << CMD_OPMODE) | (WORD_W'(1) << CMD_LOOP);

  // summary sits at bit 0 of each half; sources are relative to the half
  localparam logic [HALF_W-1:0] RX_SRC = (HALF_W'(1) << 4) | (HALF_W'(1) << 10) | (HALF_W'(1) << 11);
  localparam logic [HALF_W-1:0] TX_SRC = (HALF_W'(1) << 2) | (HALF_W'(1) << 7) | (HALF_W'(1) << 8);

  // global status flags
  localparam int GS_RXHALT = 0;
  localparam int GS_TXHALT = 1;
  localparam int GS_W      = 2;

  typedef struct packed {
    logic              enableWr;
    logic              statusClr;
    logic              cmdWr;
    logic              globalClr;
    logic              softReset;
    logic              txHaltSet;
    logic              rxHaltSet;
    logic [WORD_W-1:0] data;
  } strobeS;
endpackage

// File: rtl/irqStatusCtrl.sv
module irqStatusCtrl
  import irqStatusPkg::*;
(
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [WORD_W-1:0] regWrData,
  input  logic [WORD_W-1:0] cmdWord,
  output strobeS            strobe
);
  always_comb begin
    strobe = '0;
    strobe.data = regWrData;
    if (regWrEn) begin
      case (regSelE'(regSel))
        SEL_ENABLE:     strobe.enableWr  = 1'b1;
        SEL_STATUS_CLR: strobe.statusClr = 1'b1;
        SEL_COMMAND: begin
          if (regWrData[CMD_SWR]) begin
            strobe.softReset = 1'b1;
          end else begin
            strobe.cmdWr     = 1'b1;
            strobe.txHaltSet = cmdWord[CMD_TXON] & ~regWrData[CMD_TXON];
            strobe.rxHaltSet = cmdWord[CMD_RXON] & ~regWrData[CMD_RXON];
          end
        end
        SEL_GLOBAL_CLR: strobe.globalClr = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqStatusDatapath.sv
module irqStatusDatapath
  import irqStatusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeS            strobe,
  input  logic [HALF_W-1:0] txEvents,
  input  logic [HALF_W-1:0] rxEvents,
  output logic [WORD_W-1:0] statusWord,
  output logic [WORD_W-1:0] enableWord,
  output logic [WORD_W-1:0] cmdWord,
  output logic [WORD_W-1:0] globalStatus,
  output logic              txIrq,
  output logic              rxIrq
);
  localparam logic [WORD_W-1:0] CAUSE_MASK = ~((WORD_W'(1) << HALF_W) | WORD_W'(1));
  localparam logic [1:0][HALF_W-1:0] SUM_SRC = {TX_SRC, RX_SRC};

  logic [WORD_W-1:0] causeQ, enableQ, cmdQ, eventWord, causeNext;
  logic [GS_W-1:0]   globalQ, globalNext;
  logic [1:0]        summary, irqLine;

  assign eventWord = {txEvents, rxEvents} & CAUSE_MASK;

  always_comb begin
    causeNext = causeQ;
    if (strobe.statusClr) causeNext = causeNext & ~strobe.data;
    causeNext = causeNext | eventWord;  // set wins
  end

  always_comb begin
    globalNext = globalQ;
    if (strobe.globalClr) globalNext = globalNext & ~strobe.data[GS_W-1:0];
    if (strobe.txHaltSet) globalNext[GS_TXHALT] = 1'b1;
    if (strobe.rxHaltSet) globalNext[GS_RXHALT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeQ  <= '0;
      enableQ <= '0;
      cmdQ    <= '0;
      globalQ <= '0;
    end else if (strobe.softReset) begin
      causeQ  <= '0;
      enableQ <= '0;
      cmdQ    <= cmdQ & CMD_KEEP;
      globalQ <= '0;
    end else begin
      causeQ  <= causeNext;
      globalQ <= globalNext;
      if (strobe.enableWr) enableQ <= strobe.data;
      if (strobe.cmdWr)    cmdQ    <= strobe.data;
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign summary[h] = |(causeQ[h*HALF_W +: HALF_W] & enableQ[h*HALF_W +: HALF_W] & SUM_SRC[h]);
    assign irqLine[h] = summary[h] & enableQ[h*HALF_W];
  end

  assign statusWord   = causeQ | {HALF_W'(summary[1]), HALF_W'(summary[0])};
  assign enableWord   = enableQ;
  assign cmdWord      = cmdQ;
  assign globalStatus = WORD_W'(globalQ);
  assign txIrq        = irqLine[1];
  assign rxIrq        = irqLine[0];
endmodule

// File: rtl/irqStatusTop.sv
module irqStatusTop
  import irqStatusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [WORD_W-1:0] regWrData,
  input  logic [HALF_W-1:0] txEvents,
  input  logic [HALF_W-1:0] rxEvents,
  output logic [WORD_W-1:0] statusWord,
  output logic [WORD_W-1:0] enableWord,
  output logic [WORD_W-1:0] cmdWord,
  output logic [WORD_W-1:0] globalStatus,
  output logic              txIrq,
  output logic              rxIrq
);
  strobeS strobe;

  irqStatusCtrl uCtrl (
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .cmdWord(cmdWord), .strobe(strobe)
  );

  irqStatusDatapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txEvents(txEvents), .rxEvents(rxEvents),
    .statusWord(statusWord), .enableWord(enableWord), .cmdWord(cmdWord),
    .globalStatus(globalStatus), .txIrq(txIrq), .rxIrq(rxIrq)
  );
endmodule

// File: rtl/irqStatusChk.sv
module irqStatusChk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [1:0]  regSel,
  input logic [31:0] regWrData,
  input logic [15:0] txEvents,
  input logic [15:0] rxEvents,
  input logic [31:0] statusWord,
  input logic [31:0] enableWord,
  input logic [31:0] cmdWord,
  input logic [31:0] globalStatus,
  input logic        txIrq,
  input logic        rxIrq
);
  logic swrWrite, cmdWrite;
  assign swrWrite = regWrEn && regSel == 2'd2 && regWrData[24];
  assign cmdWrite = regWrEn && regSel == 2'd2 && !regWrData[24];

  // R2
  rx_event_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxEvents[4] && !swrWrite |=> statusWord[4]);

  // R4
  tx_set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    txEvents[8] && !swrWrite |=> statusWord[24]);

  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn && rxEvents == 16'd0 && txEvents == 16'd0 |=> $stable(statusWord));

  // R8
  tx_half_isolated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn && txEvents == 16'd0 |=> $stable(statusWord[31:16]));

  // R7
  tx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> statusWord[16] && enableWord[16]);

  // R7
  rx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[0] && enableWord[0] |-> rxIrq);

  // R9
  soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    swrWrite |=> statusWord == 32'd0 && enableWord == 32'd0 && !txIrq && !rxIrq);

  // R10
  tx_halt_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite && cmdWord[8] && !regWrData[8] |=> globalStatus[1]);
endmodule

bind irqStatusTop irqStatusChk uChk (.*);

// File: tb/tb_irqStatusTop.sv
`timescale 1ns/1ps
module tb_irqStatusTop;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWrData = 32'd0;
  logic [15:0] txEvents = 16'd0, rxEvents = 16'd0;
  logic [31:0] statusWord, enableWord, cmdWord, globalStatus;
  logic        txIrq, rxIrq;

  int errors = 0, checks = 0;
  bit done = 0;

  // model state
  logic [31:0] mCause = 0, mEn = 0, mCmd = 0;
  logic [1:0]  mGlob = 0;

  localparam logic [31:0] TXSRC = (32'd1 << 18) | (32'd1 << 23) | (32'd1 << 24);
  localparam logic [31:0] RXSRC = (32'd1 << 4) | (32'd1 << 10) | (32'd1 << 11);
  localparam logic [31:0] KEEP  = (32'd1 << 20) | (32'd1 << 21);

  always #4 clk = ~clk;

  irqStatusTop dut (.*);

  function automatic logic sumTx(); return |(mCause & mEn & TXSRC); endfunction
  function automatic logic sumRx(); return |(mCause & mEn & RXSRC); endfunction
  function automatic logic [31:0] expStatus();
    return mCause | (32'(sumTx()) << 16) | 32'(sumRx());
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " status R2"}, statusWord, expStatus());
    chk({tag, " enable R11"}, enableWord, mEn);
    chk({tag, " command R10"}, cmdWord, mCmd);
    chk({tag, " global R10"}, globalStatus, 32'(mGlob));
    chk({tag, " txIrq R7"}, 32'(txIrq), 32'(sumTx() & mEn[16]));
    chk({tag, " rxIrq R7"}, 32'(rxIrq), 32'(sumRx() & mEn[0]));
  endtask

  // one cycle of stimulus, model update, then compare at next falling edge
  task automatic step(input string tag, input logic we, input logic [1:0] sel,
                      input logic [31:0] data, input logic [15:0] te, input logic [15:0] re);
    logic [31:0] ev;
    regWrEn = we; regSel = sel; regWrData = data; txEvents = te; rxEvents = re;
    ev = {te, re} & ~32'h0001_0001;
    if (we && sel == 2'd2 && data[24]) begin
      mCause = 0; mEn = 0; mGlob = 0; mCmd = mCmd & KEEP;
    end else begin
      if (we && sel == 2'd1) mCause = mCause & ~data;
      mCause = mCause | ev;
      if (we && sel == 2'd3) mGlob = mGlob & ~data[1:0];
      if (we && sel == 2'd2) begin
        if (mCmd[8] && !data[8]) mGlob[1] = 1'b1;
        if (mCmd[0] && !data[0]) mGlob[0] = 1'b1;
        mCmd = data;
      end
      if (we && sel == 2'd0) mEn = data;
    end
    @(negedge clk);
    regWrEn = 0; txEvents = 0; rxEvents = 0;
    checkAll(tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    // R2 R5 R11: enable tx summary and done cause, then pulse done
    step("R11 enable", 1, 2'd0, 32'h0005_0011, 0, 0);
    step("R5 txdone", 0, 0, 0, 16'h0004, 0);
    chk("R5 txIrq high", 32'(txIrq), 32'd1);
    // R5: cause not in summary sources does not raise summary
    step("R3 clear", 1, 2'd1, 32'h0004_0000, 0, 0);
    step("R5 other cause", 0, 0, 0, 16'h0040, 0);
    chk("R5 summary stays low", 32'(statusWord[16]), 32'd0);
    // R6: receive good frame, summary gated by enable
    step("R6 rxgood", 0, 0, 0, 0, 16'h0010);
    chk("R6 rxIrq high", 32'(rxIrq), 32'd1);
    step("R11 drop rx summary enable", 1, 2'd0, 32'h0005_0010, 0, 0);
    chk("R7 rxIrq low", 32'(rxIrq), 32'd0);
    chk("R6 summary kept", 32'(statusWord[0]), 32'd1);
    // R4: set and clear collide
    step("R4 collide", 1, 2'd1, 32'h0000_0010, 0, 16'h0010);
    chk("R4 set wins", 32'(statusWord[4]), 32'd1);
    // R2: summary positions are not event-settable
    step("R2 summary pos", 1, 2'd0, 0, 16'h0001, 16'h0001);
    chk("R2 bit0 no store", 32'(statusWord[0]), 32'd0);
    // R8: rx event leaves tx half
    step("R8 rx only", 0, 0, 0, 0, 16'hffff);
    chk("R8 tx half", statusWord[31:16], 32'h0040);
    // R10 halted flags
    step("R10 on", 1, 2'd2, 32'h0030_0101, 0, 0);
    step("R10 tx off", 1, 2'd2, 32'h0030_0001, 0, 0);
    chk("R10 tx halt", globalStatus, 32'd2);
    step("R10 rx off", 1, 2'd2, 32'h0030_0000, 0, 0);
    step("R10 gclr", 1, 2'd3, 32'h0000_0002, 0, 0);
    chk("R10 rx halt remains", globalStatus, 32'd1);
    // R9 soft reset with events in same cycle
    step("R9 enable", 1, 2'd0, 32'hffff_ffff, 0, 0);
    step("R9 swr", 1, 2'd2, 32'h0100_0000, 16'h0104, 16'h0810);
    chk("R9 status", statusWord, 32'd0);
    chk("R9 cmd keep", cmdWord, 32'h0030_0000);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic we;
      logic [1:0] sel;
      logic [31:0] d;
      we  = ($urandom % 3) == 0;
      sel = 2'($urandom);
      d   = $urandom;
      if (sel == 2'd2 && ($urandom % 8) != 0) d[24] = 1'b0;
      if (sel == 2'd1) d = d & $urandom;
      step("rand R3", we, sel, d,
           (($urandom % 3) == 0) ? 16'($urandom & $urandom) : 16'd0,
           (($urandom % 3) == 0) ? 16'($urandom & $urandom) : 16'd0);
    end
    finishRun();
  end
endmodule